// File: doc/BRIEF.md
# Near Procedure Call Target and Push Unit

This unit handles the control-transfer arithmetic of a near subroutine call. Each call is one `start_i` pulse. With it come the address of the instruction after the call, a destination operand, an operand-size code and a relative/absolute flag. The pulse also carries the bounds the call must respect: the current code-segment limit and the number of stack bytes still free. From these the unit works out the new instruction pointer and the return address to save. It also works out the size of the ordinary stack push and whether a shadow-stack push is needed, and of what size.

The unit issues requests only. Fetching the operand, writing the stack and redirecting fetch are left to the surrounding pipeline. The result is registered and appears one clock after `start_i`, marked by a single-cycle `done_o`. When a call is illegal, the unit reports a fault code in place of the push requests and leaves the instruction pointer where it was.

Top module: `near_call_tgt`

## Requirements
- R1: `done_o` is high exactly in the cycle after a cycle with `start_i` high. `push_o` and `shpush_o` can only be high in a `done_o` cycle.
- R2: `opsize_i` encodes the operand size: 0 means 16-bit, 1 means 32-bit, and 2 or 3 mean 64-bit. For a 64-bit relative call, the new pointer is `cur_ip_i` plus `dest_i[31:0]` sign-extended to 64 bits, modulo 2^64.
- R3: For a 32-bit call, the new pointer is `(cur_ip_i + dest_i) mod 2^32` when relative and `dest_i[31:0]` when absolute. Bits 63:32 are zero.
- R4: For a 16-bit call, the new pointer is `(cur_ip_i + dest_i) mod 2^16` when relative and `dest_i[15:0]` when absolute. Bits 63:16 are zero.
- R5: A 64-bit absolute call loads all 64 bits of `dest_i` as the new pointer.
- R6: For 16-bit and 32-bit calls, a computed target strictly greater than `cs_limit_i` raises fault code 1 (general protection). A target equal to the limit is legal. 64-bit calls are never checked against the limit.
- R7: If `stack_room_i` is smaller than the return-address size (2, 4 or 8 bytes for 16, 32 or 64-bit), fault code 2 (stack fault) is raised. Code 0 means no fault.
- R8: When both faults apply, the general-protection fault (code 1) is reported. On any fault, neither push request is raised and `next_ip_o` equals the `cur_ip_i` of that call.
- R9: On a call without a fault, `push_o` is high. `push_bytes_o` is 2, 4 or 8 by operand size, and `ret_addr_o` is `cur_ip_i` truncated to that size and zero-extended.
- R10: `shpush_o` needs `shstk_en_i`. `sh_bytes_o` is 8 for 64-bit calls and 4 otherwise, and the shadow entry is `ret_addr_o`, so a 16-bit pointer is zero-extended.
- R11: A relative call whose displacement is zero gives no shadow push. The displacement checked is `dest_i[15:0]` for 16-bit calls and `dest_i[31:0]` otherwise. An absolute call always gives a shadow push when shadow stacks are enabled, whatever its destination.
- R12: After reset, all outputs are zero. `next_ip_o` and `fault_o` keep their last values in cycles without `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to evaluate a call |
| is_rel_i | input | 1 | 1 = relative displacement, 0 = absolute destination |
| opsize_i | input | 2 | Operand size code (0:16, 1:32, 2/3:64) |
| cur_ip_i | input | 64 | Address of the instruction following the call |
| dest_i | input | 64 | Destination operand or displacement |
| cs_limit_i | input | 32 | Code-segment limit |
| stack_room_i | input | 16 | Free stack bytes |
| shstk_en_i | input | 1 | Shadow stack enabled |
| done_o | output | 1 | Result valid strobe |
| next_ip_o | output | 64 | New instruction pointer |
| fault_o | output | 2 | 0 none, 1 general protection, 2 stack fault |
| push_o | output | 1 | Stack push request |
| push_bytes_o | output | 4 | Stack push size in bytes |
| ret_addr_o | output | 64 | Return address to push |
| shpush_o | output | 1 | Shadow-stack push request |
| sh_bytes_o | output | 4 | Shadow-stack push size in bytes |

## Verification
The bench targets wraparound in 16-bit and 32-bit relative arithmetic. A unit that did not mask would return a target above the low word and would then also trip the limit check wrongly. It drives targets exactly at the limit and one past it, and stack room exactly at the push size and one byte short. Off-by-one comparisons show up there as false or missing faults. It raises both faults together to expose reversed priority. It uses zero displacements, including a 16-bit one with nonzero upper operand bits and an absolute call to address zero. A unit that dropped the zero rule, or that tested the wrong width, would issue or skip the shadow push wrongly.

// File: rtl/ncall_pkg.sv
package ncall_pkg;

    typedef enum logic [1:0] {
        OPS_16 = 2'd0,
        OPS_32 = 2'd1,
        OPS_64 = 2'd2
    } ops_e;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_GP   = 2'd1,
        FLT_SS   = 2'd2
    } flt_e;

    localparam int unsigned HALF_W = 16;
    localparam int unsigned WORD_W = 32;

endpackage

// File: rtl/ncall_target.sv
module ncall_target
    import ncall_pkg::*;
#(
    parameter int unsigned IP_W   = 64,
    parameter int unsigned DISP_W = 32,
    parameter int unsigned LIM_W  = 32
) (
    input  logic              is_rel,
    input  ops_e              size,
    input  logic [IP_W-1:0]   cur_ip,
    input  logic [IP_W-1:0]   dest,
    input  logic [LIM_W-1:0]  cs_limit,
    output logic [IP_W-1:0]   target,
    output logic              lim_fault,
    output logic              disp_zero
);
    localparam int unsigned EXT_W = IP_W - DISP_W;
    localparam int unsigned LPAD  = IP_W - LIM_W;

    logic [IP_W-1:0]   disp_sx;
    logic [IP_W-1:0]   sum_wide;
    logic [WORD_W-1:0] sum_word;
    logic [HALF_W-1:0] sum_half;
    logic [IP_W-1:0]   lim_wide;

    always_comb begin
        disp_sx  = {{EXT_W{dest[DISP_W-1]}}, dest[DISP_W-1:0]};
        sum_wide = cur_ip + disp_sx;
        sum_word = cur_ip[WORD_W-1:0] + dest[WORD_W-1:0];
        sum_half = cur_ip[HALF_W-1:0] + dest[HALF_W-1:0];
        lim_wide = {{LPAD{1'b0}}, cs_limit};

        unique case (size)
            OPS_16: target = {{(IP_W-HALF_W){1'b0}},
                              is_rel ? sum_half : dest[HALF_W-1:0]};
            OPS_32: target = {{(IP_W-WORD_W){1'b0}},
                              is_rel ? sum_word : dest[WORD_W-1:0]};
            default: target = is_rel ? sum_wide : dest;
        endcase

        lim_fault = (size != OPS_64) && (target > lim_wide);
        disp_zero = (size == OPS_16) ? (dest[HALF_W-1:0] == '0)
                                     : (dest[DISP_W-1:0] == '0);
    end

endmodule

// File: rtl/ncall_push.sv
module ncall_push
    import ncall_pkg::*;
#(
    parameter int unsigned IP_W   = 64,
    parameter int unsigned ROOM_W = 16
) (
    input  logic              is_rel,
    input  ops_e              size,
    input  logic [IP_W-1:0]   cur_ip,
    input  logic [ROOM_W-1:0] room,
    input  logic              sh_en,
    input  logic              disp_zero,
    output logic [3:0]        need_bytes,
    output logic              ss_fault,
    output logic              sh_req,
    output logic [3:0]        sh_bytes,
    output logic [IP_W-1:0]   ret_addr
);
    always_comb begin
        unique case (size)
            OPS_16: begin
                need_bytes = 4'd2;
                ret_addr   = {{(IP_W-HALF_W){1'b0}}, cur_ip[HALF_W-1:0]};
            end
            OPS_32: begin
                need_bytes = 4'd4;
                ret_addr   = {{(IP_W-WORD_W){1'b0}}, cur_ip[WORD_W-1:0]};
            end
            default: begin
                need_bytes = 4'd8;
                ret_addr   = cur_ip;
            end
        endcase
        ss_fault = room < ROOM_W'(need_bytes);
        sh_bytes = (size == OPS_64) ? 4'd8 : 4'd4;
        sh_req   = sh_en && !(is_rel && disp_zero);
    end

endmodule

// File: rtl/near_call_tgt.sv
module near_call_tgt
    import ncall_pkg::*;
#(
    parameter int unsigned IP_W   = 64,
    parameter int unsigned DISP_W = 32,
    parameter int unsigned LIM_W  = 32,
    parameter int unsigned ROOM_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              is_rel_i,
    input  logic [1:0]        opsize_i,
    input  logic [IP_W-1:0]   cur_ip_i,
    input  logic [IP_W-1:0]   dest_i,
    input  logic [LIM_W-1:0]  cs_limit_i,
    input  logic [ROOM_W-1:0] stack_room_i,
    input  logic              shstk_en_i,
    output logic              done_o,
    output logic [IP_W-1:0]   next_ip_o,
    output logic [1:0]        fault_o,
    output logic              push_o,
    output logic [3:0]        push_bytes_o,
    output logic [IP_W-1:0]   ret_addr_o,
    output logic              shpush_o,
    output logic [3:0]        sh_bytes_o
);
    typedef struct packed {
        logic            done;
        logic [IP_W-1:0] next_ip;
        flt_e            fault;
        logic            push;
        logic [3:0]      push_bytes;
        logic [IP_W-1:0] ret_addr;
        logic            shpush;
        logic [3:0]      sh_bytes;
    } res_t;

    ops_e            size;
    logic [IP_W-1:0] target;
    logic            lim_fault;
    logic            disp_zero;
    logic [3:0]      need_bytes;
    logic            ss_fault;
    logic            sh_req;
    logic [3:0]      sh_bytes;
    logic [IP_W-1:0] ret_addr;
    res_t            st_d;
    res_t            st_q;

    always_comb begin
        unique case (opsize_i)
            2'd0:    size = OPS_16;
            2'd1:    size = OPS_32;
            default: size = OPS_64;
        endcase
    end

    ncall_target #(
        .IP_W  (IP_W),
        .DISP_W(DISP_W),
        .LIM_W (LIM_W)
    ) target_i (
        .is_rel   (is_rel_i),
        .size     (size),
        .cur_ip   (cur_ip_i),
        .dest     (dest_i),
        .cs_limit (cs_limit_i),
        .target   (target),
        .lim_fault(lim_fault),
        .disp_zero(disp_zero)
    );

    ncall_push #(
        .IP_W  (IP_W),
        .ROOM_W(ROOM_W)
    ) push_i (
        .is_rel    (is_rel_i),
        .size      (size),
        .cur_ip    (cur_ip_i),
        .room      (stack_room_i),
        .sh_en     (shstk_en_i),
        .disp_zero (disp_zero),
        .need_bytes(need_bytes),
        .ss_fault  (ss_fault),
        .sh_req    (sh_req),
        .sh_bytes  (sh_bytes),
        .ret_addr  (ret_addr)
    );

    always_comb begin
        st_d        = st_q;
        st_d.done   = 1'b0;
        st_d.push   = 1'b0;
        st_d.shpush = 1'b0;
        if (start_i) begin
            st_d.done       = 1'b1;
            st_d.push_bytes = need_bytes;
            st_d.sh_bytes   = sh_bytes;
            st_d.ret_addr   = ret_addr;
            if (lim_fault) begin
                st_d.fault   = FLT_GP;
                st_d.next_ip = cur_ip_i;
            end else if (ss_fault) begin
                st_d.fault   = FLT_SS;
                st_d.next_ip = cur_ip_i;
            end else begin
                st_d.fault   = FLT_NONE;
                st_d.next_ip = target;
                st_d.push    = 1'b1;
                st_d.shpush  = sh_req;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o       = st_q.done;
    assign next_ip_o    = st_q.next_ip;
    assign fault_o      = st_q.fault;
    assign push_o       = st_q.push;
    assign push_bytes_o = st_q.push_bytes;
    assign ret_addr_o   = st_q.ret_addr;
    assign shpush_o     = st_q.shpush;
    assign sh_bytes_o   = st_q.sh_bytes;

endmodule

// File: rtl/ncall_chk.sv
module ncall_chk #(
    parameter int unsigned IP_W = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start_i,
    input logic [1:0]      opsize_i,
    input logic [IP_W-1:0] cur_ip_i,
    input logic            done_o,
    input logic [IP_W-1:0] next_ip_o,
    input logic [1:0]      fault_o,
    input logic            push_o,
    input logic [3:0]      push_bytes_o,
    input logic            shpush_o
);
    AST_DONE_FOLLOWS_START: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> done_o);  // R1
    AST_STROBE_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (push_o || shpush_o) |-> done_o);  // R1
    AST_FAULT_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && fault_o != 2'd0) |-> (!push_o && !shpush_o));  // R8
    AST_FAULT_IP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (fault_o == 2'd0 || next_ip_o == $past(cur_ip_i)));  // R8
    AST_IP16_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && opsize_i == 2'd0) |=> (fault_o != 2'd0 || next_ip_o[IP_W-1:16] == '0));  // R4
    AST_SH_NEEDS_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        shpush_o |-> push_o);  // R10
    AST_PUSH_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |-> ($countones(push_bytes_o) == 1 && push_bytes_o >= 4'd2));  // R9
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(next_ip_o) && $stable(fault_o)));  // R12
endmodule

bind near_call_tgt ncall_chk #(.IP_W(IP_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .opsize_i    (opsize_i),
    .cur_ip_i    (cur_ip_i),
    .done_o      (done_o),
    .next_ip_o   (next_ip_o),
    .fault_o     (fault_o),
    .push_o      (push_o),
    .push_bytes_o(push_bytes_o),
    .shpush_o    (shpush_o)
);

// File: tb/near_call_tgt_tb_top.sv
`timescale 1ns/1ps
module near_call_tgt_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        is_rel_i = 1'b0;
    logic [1:0]  opsize_i = 2'd0;
    logic [63:0] cur_ip_i = '0;
    logic [63:0] dest_i = '0;
    logic [31:0] cs_limit_i = '0;
    logic [15:0] stack_room_i = '0;
    logic        shstk_en_i = 1'b0;
    logic        done_o;
    logic [63:0] next_ip_o;
    logic [1:0]  fault_o;
    logic        push_o;
    logic [3:0]  push_bytes_o;
    logic [63:0] ret_addr_o;
    logic        shpush_o;
    logic [3:0]  sh_bytes_o;

    int checks = 0;
    int errors = 0;

    // expected state of the behavioural model
    bit          pend = 0;
    logic [63:0] m_ip = '0;
    int          m_flt = 0;
    bit          m_push = 0;
    int          m_pbytes = 0;
    logic [63:0] m_ret = '0;
    bit          m_sh = 0;
    int          m_shbytes = 0;

    always #2 clk = ~clk;

    near_call_tgt dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .is_rel_i(is_rel_i),
        .opsize_i(opsize_i), .cur_ip_i(cur_ip_i), .dest_i(dest_i),
        .cs_limit_i(cs_limit_i), .stack_room_i(stack_room_i),
        .shstk_en_i(shstk_en_i), .done_o(done_o), .next_ip_o(next_ip_o),
        .fault_o(fault_o), .push_o(push_o), .push_bytes_o(push_bytes_o),
        .ret_addr_o(ret_addr_o), .shpush_o(shpush_o), .sh_bytes_o(sh_bytes_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic compare();
        chk(done_o == pend, "R1 done", 64'(done_o), 64'(pend));
        chk(next_ip_o == m_ip, "R2/R3/R4/R5/R12 next_ip", next_ip_o, m_ip);
        chk(fault_o == 2'(m_flt), "R6/R7/R8 fault", 64'(fault_o), 64'(m_flt));
        chk(push_o == (pend && m_push), "R8/R9 push", 64'(push_o), 64'(pend && m_push));
        chk(shpush_o == (pend && m_sh), "R10/R11 shpush", 64'(shpush_o), 64'(pend && m_sh));
        if (pend) begin
            chk(push_bytes_o == 4'(m_pbytes), "R9 push_bytes", 64'(push_bytes_o), 64'(m_pbytes));
            chk(ret_addr_o == m_ret, "R9 ret_addr", ret_addr_o, m_ret);
            chk(sh_bytes_o == 4'(m_shbytes), "R10 sh_bytes", 64'(sh_bytes_o), 64'(m_shbytes));
        end
    endtask

    // one clock: check last cycle's result, then drive and predict the next one
    task automatic step(input bit st, input bit rel, input int op, input logic [63:0] ip,
                        input logic [63:0] dst, input logic [31:0] lim,
                        input int room, input bit sh);
        longint unsigned mask, t;
        int bits;
        bit gp, ss, dz;
        @(negedge clk);
        compare();
        start_i = st; is_rel_i = rel; opsize_i = 2'(op); cur_ip_i = ip;
        dest_i = dst; cs_limit_i = lim; stack_room_i = 16'(room); shstk_en_i = sh;
        pend = st;
        if (st) begin
            bits = (op == 0) ? 16 : (op == 1) ? 32 : 64;
            mask = (bits == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << bits) - 64'd1);
            if (rel && bits == 64) t = ip + longint'(int'(dst[31:0]));
            else if (rel)          t = (ip + dst) & mask;
            else                   t = dst & mask;
            gp = (bits != 64) && (t > longint'(lim));
            ss = room < bits / 8;
            dz = (dst & ((bits == 16) ? 64'hFFFF : 64'hFFFF_FFFF)) == 0;
            m_pbytes = bits / 8;
            m_shbytes = (bits == 64) ? 8 : 4;
            m_ret = ip & mask;
            m_flt = gp ? 1 : (ss ? 2 : 0);
            m_ip = (gp || ss) ? ip : t;
            m_push = !(gp || ss);
            m_sh = m_push && sh && !(rel && dz);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R12 reset state
        step(0, 0, 0, 0, 0, 0, 0, 0);
        chk(ret_addr_o == 0 && push_bytes_o == 0 && sh_bytes_o == 0, "R12 reset",
            {ret_addr_o[55:0], push_bytes_o, sh_bytes_o}, 0);
        // R2 64-bit relative, negative and positive displacement
        step(1, 1, 2, 64'h0000_7FFF_0000_1000, 64'h0000_0000_FFFF_FF00, 0, 8, 1);
        step(1, 1, 2, 64'hFFFF_FFFF_FFFF_FFF0, 64'h0000_0000_0000_0020, 0, 100, 1);
        step(1, 1, 3, 64'h1234_5678_9ABC_DEF0, 64'hFFFF_FFFF_8000_0000, 0, 8, 0);
        // R5 64-bit absolute, no limit check (R6)
        step(1, 0, 2, 64'h10, 64'hDEAD_BEEF_CAFE_F00D, 32'h0, 8, 1);
        // R3 32-bit relative wraparound and absolute
        step(1, 1, 1, 64'hAAAA_0000_FFFF_FFF0, 64'h0000_0000_0000_0020, 32'hFFFF_FFFF, 4, 1);
        step(1, 0, 1, 64'h5, 64'hFFFF_0000_0000_1234, 32'h1234, 4, 1);
        // R4 16-bit relative wrap and absolute with upper junk
        step(1, 1, 0, 64'h0001_0002_0003_FFF0, 64'h0000_0000_0000_0020, 32'hFFFF, 2, 1);
        step(1, 0, 0, 64'h0, 64'hFFFF_FFFF_FFFF_8001, 32'hFFFF, 2, 0);
        // R6 limit boundary: equal passes, one past faults
        step(1, 0, 1, 64'h100, 64'h0000_0000_0000_4000, 32'h4000, 8, 1);
        step(1, 0, 1, 64'h100, 64'h0000_0000_0000_4001, 32'h4000, 8, 1);
        step(1, 1, 0, 64'hFF00, 64'h0000_0000_0000_0100, 32'h7FFF, 8, 1);
        // R7 stack room boundary per size
        step(1, 1, 2, 64'h4000, 64'h10, 0, 7, 1);
        step(1, 1, 1, 64'h4000, 64'h10, 32'hFFFF, 3, 1);
        step(1, 1, 1, 64'h4000, 64'h10, 32'hFFFF, 4, 1);
        step(1, 1, 0, 64'h4000, 64'h10, 32'hFFFF, 1, 1);
        step(1, 1, 0, 64'h4000, 64'h10, 32'hFFFF, 2, 1);
        // R8 both faults: GP wins
        step(1, 0, 1, 64'h77, 64'h9000, 32'h8000, 0, 1);
        // R11 zero displacements and absolute zero
        step(1, 1, 2, 64'h8888, 64'hFFFF_FFFF_0000_0000, 0, 8, 1);
        step(1, 1, 0, 64'h8888, 64'h0000_0000_5555_0000, 32'hFFFF, 8, 1);
        step(1, 1, 1, 64'h8888, 64'h0000_0000_0001_0000, 32'hFFFF_FFFF, 8, 1);
        step(1, 0, 2, 64'h8888, 64'h0, 0, 8, 1);
        // R12 idle hold
        step(0, 1, 2, 64'h1, 64'h1, 0, 8, 1);
        step(0, 0, 0, 64'h2, 64'h2, 0, 0, 0);
        // random mix with gaps
        for (int i = 0; i < 400; i++) begin
            logic [63:0] rip, rdst;
            rip = {$urandom, $urandom};
            rdst = {$urandom, $urandom};
            if ($urandom_range(0, 3) == 0) rdst[31:0] = 0;
            step($urandom_range(0, 3) != 0, 1'($urandom), int'($urandom_range(0, 3)),
                 rip, rdst, ($urandom_range(0, 1) != 0) ? 32'hFFFF_FFFF : $urandom,
                 int'($urandom_range(0, 10)), 1'($urandom));
        end
        step(0, 0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule